// File: doc/BRIEF.md
# Memory Write Protection Controller

This block sits beside a two-wire serial memory slave and rules on every write it sees. It uses the write-protect pin, the address strap levels and two protection flags to decide whether each data byte may change the 256-byte array. One flag is permanent and the other is reversible. While either flag is set, only the lower half of the array is locked. The pin locks the whole array. The slave controller does the bit timing. It passes on start and stop events, each received control byte and each received byte after it. The block replies with an acknowledge decision, a per-byte write enable with its address, and a busy window that models the self-timed write cycle.

A second control-byte family, with preamble 0110, sets, clears and queries the two flags. A flag's state can only be learned from whether that control byte is acknowledged. Flag changes take effect at the end of the write cycle that follows the command's stop. At that moment the block raises a one-cycle program request, so that a nonvolatile backing store can record the change. The flags are held in flops that load preset values at reset.

Top module: `wprot_ctrl`

## Requirements
- R1: A control byte with preamble 1010 (bits 7:4) whose bits 3:1 equal the strap levels is acknowledged for either R/W value (bit 0, 1 = read). Any other preamble, or a strap mismatch, is not acknowledged.
- R2: While the pin `wp_pin` is high, no data byte is write-enabled at any address. The array control byte is still acknowledged.
- R3: With `wp_pin` low and either flag set, data bytes addressed 00h–7Fh are not write-enabled and bytes addressed 80h–FFh are.
- R4: In an acknowledged array write, the first byte after the control byte is the word address and is never write-enabled. Each later byte is write-enabled at the current address, one cycle after it arrives, and only the low 4 address bits then increment, wrapping within the 16-byte page.
- R5: Control byte 0110 followed by the straps and R/W=0, with `a0_hv` low, is acknowledged while the permanent flag is clear. After the write cycle the permanent flag is set and `prog_op` reports code 1.
- R6: Once the permanent flag is set, no 0110 control byte is acknowledged, and the flag never clears.
- R7: Control byte 62h, with straps A2 and A1 low and `a0_hv` high, is acknowledged only when both flags are clear. After the write cycle it sets the reversible flag, with `prog_op` code 2.
- R8: Control byte 66h, with strap A2 low, A1 high and `a0_hv` high, is acknowledged when the permanent flag is clear. After the write cycle it clears the reversible flag, with `prog_op` code 3.
- R9: A 0110 control byte with R/W=1 is a query. The permanent query is acknowledged if and only if the permanent flag is clear. The reversible query (63h or 67h) is acknowledged if and only if both flags are clear. After an acknowledged query, `query_ff` stays high until the next stop or start.
- R10: A flag command whose stop arrives while `wp_pin` is high changes no flag and raises no program request, although its write cycle still runs.
- R11: The stop of an acknowledged write that carried at least one data byte after the word address makes `busy` high for exactly TWR_CYCLES cycles, starting in the cycle after the stop. Any flag update and the `prog_req` pulse occur in the first cycle with `busy` low. A write that carries no data byte starts no cycle.
- R12: While `busy` is high, no control byte is acknowledged.
- R13: Reset loads the flags from `perm_preset` and `rev_preset`, and clears `ack_valid`, `ack_ok`, `wr_en`, `busy`, `prog_req` and `query_ff`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Hardware write-protect level |
| strap | input | 3 | Address strap levels A2..A0 |
| a0_hv | input | 1 | A0 strap is at high voltage |
| perm_preset | input | 1 | Permanent flag value loaded at reset |
| rev_preset | input | 1 | Reversible flag value loaded at reset |
| bus_start | input | 1 | Start or repeated start seen |
| bus_stop | input | 1 | Stop seen |
| ctrl_valid | input | 1 | Control byte received this cycle |
| ctrl_byte | input | 8 | Control byte, bit 0 = R/W |
| byte_valid | input | 1 | Byte after the control byte received |
| byte_data | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack_ok | output | 1 | Control byte is acknowledged |
| wr_en | output | 1 | Array byte may be written |
| wr_addr | output | 8 | Array address for `wr_en` |
| query_ff | output | 1 | Read data must be FFh (status query) |
| busy | output | 1 | Timed write cycle running |
| prog_req | output | 1 | Flag changed this cycle |
| prog_op | output | 2 | 1 perm set, 2 rev set, 3 rev clear |

## Verification
The bench targets the half-array boundary at 7Fh/80h with each flag on its own. A design that decoded the wrong address bit would then lock or open the wrong half. It starts a page write at 0Eh, where a design that carried into the upper address bits would leave the page. It keeps `wp_pin` high at the stop of a flag command, where a design that took the pin only at the control byte would change a flag. It also issues control bytes during the write cycle, after the permanent flag is set, and with the reversible flag already set. A design with a wrong acknowledge rule would reveal a flag state it should hide, or accept a command it must refuse.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam logic [3:0] PRE_ARRAY   = 4'hA;
    localparam logic [3:0] PRE_PROT    = 4'h6;
    localparam logic [2:0] SEL_REV_SET = 3'b001;
    localparam logic [2:0] SEL_REV_CLR = 3'b011;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ARRAY,
        CMD_PERM,
        CMD_REV_SET,
        CMD_REV_CLR
    } cmd_kind_e;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_PERM    = 2'd1,
        OP_REV_SET = 2'd2,
        OP_REV_CLR = 2'd3
    } flag_op_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      rd;
    } ctrl_dec_t;

    typedef struct packed {
        logic perm;
        logic rev;
    } flags_t;

    // Classify a control byte against the strap levels and the A0 high-voltage state.
    function automatic ctrl_dec_t decode_ctrl(input logic [7:0] cb,
                                              input logic [2:0] strap,
                                              input logic       hv);
        ctrl_dec_t d;
        d.rd   = cb[0];
        d.kind = CMD_NONE;
        if (cb[7:4] == PRE_ARRAY && cb[3:1] == strap) begin
            d.kind = CMD_ARRAY;
        end else if (cb[7:4] == PRE_PROT) begin
            if (hv) begin
                if (cb[3:1] == SEL_REV_SET && strap[2:1] == 2'b00)
                    d.kind = CMD_REV_SET;
                else if (cb[3:1] == SEL_REV_CLR && strap[2:1] == 2'b01)
                    d.kind = CMD_REV_CLR;
            end else if (cb[3:1] == strap) begin
                d.kind = CMD_PERM;
            end
        end
        return d;
    endfunction

    function automatic flag_op_e kind_to_op(input cmd_kind_e k);
        case (k)
            CMD_PERM:    return OP_PERM;
            CMD_REV_SET: return OP_REV_SET;
            CMD_REV_CLR: return OP_REV_CLR;
            default:     return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
    import wprot_pkg::*;
(
    input  logic [7:0] ctrl_byte,
    input  logic [2:0] strap,
    input  logic       a0_hv,
    input  flags_t     flags,
    input  logic       busy,
    output ctrl_dec_t  dec,
    output logic       ack
);
    always_comb begin
        dec = decode_ctrl(ctrl_byte, strap, a0_hv);
        ack = 1'b0;
        if (!busy) begin
            case (dec.kind)
                CMD_ARRAY:   ack = 1'b1;
                CMD_PERM:    ack = !flags.perm;
                CMD_REV_SET: ack = !flags.perm && !flags.rev;
                CMD_REV_CLR: ack = dec.rd ? (!flags.perm && !flags.rev) : !flags.perm;
                default:     ack = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wprot_flags.sv
module wprot_flags
    import wprot_pkg::*;
#(
    parameter int TWR_CYCLES = 50
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     perm_preset,
    input  logic     rev_preset,
    input  logic     cycle_start,
    input  flag_op_e cycle_op,
    output flags_t   flags,
    output logic     busy,
    output logic     prog_req,
    output flag_op_e prog_op
);
    localparam int CNT_W = $clog2(TWR_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    flag_op_e         pend_q;

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags.perm <= perm_preset;
            flags.rev  <= rev_preset;
            cnt_q      <= '0;
            pend_q     <= OP_NONE;
            prog_req   <= 1'b0;
            prog_op    <= OP_NONE;
        end else begin
            prog_req <= 1'b0;
            if (cycle_start) begin
                cnt_q  <= CNT_W'(TWR_CYCLES);
                pend_q <= cycle_op;
            end else if (busy) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    prog_req <= (pend_q != OP_NONE);
                    prog_op  <= pend_q;
                    case (pend_q)
                        OP_PERM:    flags.perm <= 1'b1;
                        OP_REV_SET: flags.rev  <= 1'b1;
                        OP_REV_CLR: flags.rev  <= 1'b0;
                        default:    ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/wprot_page_ptr.sv
module wprot_page_ptr
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              is_addr,
    input  logic [7:0]        data,
    input  logic              to_array,
    input  logic              wp_pin,
    input  flags_t            flags,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_next;
    logic              low_half;
    logic              allowed;

    generate
        if (PAGE_W >= ADDR_W) begin : g_flat
            assign ptr_next = ptr_q + ADDR_W'(1);
        end else begin : g_paged
            assign ptr_next = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
        end
    endgenerate

    assign low_half = !ptr_q[ADDR_W-1];
    assign allowed  = to_array && !wp_pin && !(low_half && (flags.perm || flags.rev));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
        end else begin
            wr_en <= 1'b0;
            if (load) begin
                if (is_addr) begin
                    ptr_q <= ADDR_W'(data);
                end else begin
                    wr_en   <= allowed;
                    wr_addr <= ptr_q;
                    ptr_q   <= ptr_next;
                end
            end
        end
    end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGE_W     = 4,
    parameter int TWR_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_pin,
    input  logic [2:0]        strap,
    input  logic              a0_hv,
    input  logic              perm_preset,
    input  logic              rev_preset,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              ctrl_valid,
    input  logic [7:0]        ctrl_byte,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              ack_valid,
    output logic              ack_ok,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              query_ff,
    output logic              busy,
    output logic              prog_req,
    output logic [1:0]        prog_op
);
    ctrl_dec_t dec;
    logic      ack;
    flags_t    flags;
    flag_op_e  prog_op_e;

    cmd_kind_e txn_kind;
    logic      txn_wr, txn_ack, have_addr, data_seen;
    logic      perm_q, rev_q;
    logic      byte_load, cycle_start;
    flag_op_e  cycle_op;

    assign perm_q = flags.perm;
    assign rev_q  = flags.rev;

    wprot_decode u_dec (
        .ctrl_byte (ctrl_byte),
        .strap     (strap),
        .a0_hv     (a0_hv),
        .flags     (flags),
        .busy      (busy),
        .dec       (dec),
        .ack       (ack)
    );

    assign byte_load   = byte_valid && txn_ack && txn_wr;
    assign cycle_start = bus_stop && txn_ack && txn_wr && data_seen && !busy;
    assign cycle_op    = wp_pin ? OP_NONE : kind_to_op(txn_kind);

    wprot_flags #(.TWR_CYCLES(TWR_CYCLES)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .perm_preset (perm_preset),
        .rev_preset  (rev_preset),
        .cycle_start (cycle_start),
        .cycle_op    (cycle_op),
        .flags       (flags),
        .busy        (busy),
        .prog_req    (prog_req),
        .prog_op     (prog_op_e)
    );
    assign prog_op = prog_op_e;

    wprot_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (byte_load),
        .is_addr  (!have_addr),
        .data     (byte_data),
        .to_array (txn_kind == CMD_ARRAY),
        .wp_pin   (wp_pin),
        .flags    (flags),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            txn_kind  <= CMD_NONE;
            txn_wr    <= 1'b0;
            txn_ack   <= 1'b0;
            have_addr <= 1'b0;
            data_seen <= 1'b0;
            ack_valid <= 1'b0;
            ack_ok    <= 1'b0;
            query_ff  <= 1'b0;
        end else begin
            ack_valid <= ctrl_valid;
            ack_ok    <= ctrl_valid && ack;
            if (bus_start || bus_stop) begin
                txn_ack   <= 1'b0;
                have_addr <= 1'b0;
                data_seen <= 1'b0;
                query_ff  <= 1'b0;
            end else if (ctrl_valid) begin
                txn_kind  <= dec.kind;
                txn_wr    <= !dec.rd;
                txn_ack   <= ack;
                have_addr <= 1'b0;
                data_seen <= 1'b0;
                query_ff  <= ack && dec.rd &&
                             (dec.kind == CMD_PERM || dec.kind == CMD_REV_SET ||
                              dec.kind == CMD_REV_CLR);
            end else if (byte_load) begin
                if (!have_addr) have_addr <= 1'b1;
                else            data_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wp_pin,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              perm_q,
    input logic              rev_q,
    input logic              ack_valid,
    input logic              ack_ok,
    input logic              busy,
    input logic              prog_req
);
    // R2
    wp_block_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(wp_pin));

    // R3
    low_half_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr[ADDR_W-1]) |-> (!$past(perm_q) && !$past(rev_q)));

    // R6
    perm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(perm_q));

    // R11
    flag_change_chk: assert property (@(posedge clk) disable iff (rst)
        ((perm_q != $past(perm_q)) || (rev_q != $past(rev_q))) |-> prog_req);

    // R11
    prog_edge_chk: assert property (@(posedge clk) disable iff (rst)
        prog_req |-> (!busy && $past(busy)));

    // R12
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && $past(busy)) |-> !ack_ok);
endmodule

bind wprot_ctrl wprot_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wp_pin    (wp_pin),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .perm_q    (perm_q),
    .rev_q     (rev_q),
    .ack_valid (ack_valid),
    .ack_ok    (ack_ok),
    .busy      (busy),
    .prog_req  (prog_req)
);

// File: tb/tb_wprot_ctrl.sv
module tb_wprot_ctrl;
    localparam int TWR = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wp_pin = 1'b0, a0_hv = 1'b0, perm_preset = 1'b0, rev_preset = 1'b0;
    logic [2:0] strap = 3'b000;
    logic       bus_start = 1'b0, bus_stop = 1'b0, ctrl_valid = 1'b0, byte_valid = 1'b0;
    logic [7:0] ctrl_byte = '0, byte_data = '0;
    logic       ack_valid, ack_ok, wr_en, query_ff, busy, prog_req;
    logic [7:0] wr_addr;
    logic [1:0] prog_op;

    int n_chk = 0, n_bad = 0;
    bit m_perm = 0, m_rev = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wprot_ctrl #(.ADDR_W(8), .PAGE_W(4), .TWR_CYCLES(TWR)) dut (
        .clk(clk), .rst(rst), .wp_pin(wp_pin), .strap(strap), .a0_hv(a0_hv),
        .perm_preset(perm_preset), .rev_preset(rev_preset),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .ctrl_valid(ctrl_valid), .ctrl_byte(ctrl_byte),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .ack_valid(ack_valid), .ack_ok(ack_ok), .wr_en(wr_en), .wr_addr(wr_addr),
        .query_ff(query_ff), .busy(busy), .prog_req(prog_req), .prog_op(prog_op)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 none, 1 array, 2 perm, 3 rev set, 4 rev clear
    function automatic int m_kind(input logic [7:0] cb, input logic [2:0] s, input logic hv);
        if (cb[7:4] == 4'hA) return (cb[3:1] == s) ? 1 : 0;
        if (cb[7:4] != 4'h6) return 0;
        if (hv) begin
            if (cb[3:1] == 3'b001 && s[2:1] == 2'b00) return 3;
            if (cb[3:1] == 3'b011 && s[2:1] == 2'b01) return 4;
            return 0;
        end
        return (cb[3:1] == s) ? 2 : 0;
    endfunction

    function automatic bit m_ack(input int k, input bit rd);
        case (k)
            1: return 1;
            2: return !m_perm;
            3: return !m_perm && !m_rev;
            4: return rd ? (!m_perm && !m_rev) : !m_perm;
            default: return 0;
        endcase
    endfunction

    task automatic do_reset(input bit pp, input bit rp);
        perm_preset = pp; rev_preset = rp; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_perm = pp; m_rev = rp;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 1000) begin guard++; @(negedge clk); end
    endtask

    // nbytes < 0: no word address byte; 0: word address only (dummy write)
    task automatic txn(input logic [7:0] cb, input int nbytes, input logic [7:0] addr);
        int  k;
        bit  rd, a, wpv, ew;
        int  exp_op, bcnt;
        logic [7:0] p;
        k = m_kind(cb, strap, a0_hv);
        rd = cb[0];
        a = m_ack(k, rd);
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) begin bus_start = 1'b0; ctrl_valid = 1'b1; ctrl_byte = cb; end
        @(negedge clk) ctrl_valid = 1'b0;
        chk($sformatf("R1/R5-R9 ack cb=%0h", cb), ack_ok, a);
        chk("R9 query_ff after control byte", query_ff, (a && rd && k >= 2) ? 1 : 0);
        if (!rd && a && nbytes >= 0) begin
            byte_valid = 1'b1; byte_data = addr;
            @(negedge clk) byte_valid = 1'b0;
            chk("R4 word address not written", wr_en, 0);
            p = addr;
            for (int i = 0; i < nbytes; i++) begin
                byte_valid = 1'b1; byte_data = 8'($urandom);
                @(negedge clk) byte_valid = 1'b0;
                ew = (k == 1) && !wp_pin && !(p[7] == 1'b0 && (m_perm || m_rev));
                chk($sformatf("R2/R3/R4 wr_en at %0h", p), wr_en, ew);
                if (ew) chk("R4 wr_addr", wr_addr, p);
                p = {p[7:4], 4'(p[3:0] + 4'd1)};
            end
        end
        wpv = wp_pin;
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        chk("R9 query_ff cleared by stop", query_ff, 0);
        if (!rd && a && nbytes >= 1) begin
            bcnt = 0;
            while (busy && bcnt < 1000) begin bcnt++; @(negedge clk); end
            chk("R11 busy length", bcnt, TWR);
            exp_op = 0;
            if (!wpv) exp_op = (k == 2) ? 1 : (k == 3) ? 2 : (k == 4) ? 3 : 0;
            chk("R10/R11 prog_req", prog_req, exp_op != 0);
            if (exp_op != 0) chk("R5/R7/R8 prog_op", prog_op, exp_op);
            if (exp_op == 1) m_perm = 1;
            if (exp_op == 2) m_rev = 1;
            if (exp_op == 3) m_rev = 0;
        end else begin
            chk("R11 no write cycle", busy, 0);
        end
    endtask

    task automatic set_pins(input bit w, input logic [2:0] s, input bit hv);
        wp_pin = w; strap = s; a0_hv = hv;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h5eed_1234;
        void'($urandom(seed));
        do_reset(0, 0);
        // R13 reset state
        chk("R13 ack_valid", ack_valid, 0);
        chk("R13 wr_en", wr_en, 0);
        chk("R13 busy", busy, 0);
        chk("R13 prog_req", prog_req, 0);
        chk("R13 query_ff", query_ff, 0);

        // R4 page wrap from 0Eh
        set_pins(0, 3'b101, 0);
        txn(8'hAA, 4, 8'h0E);
        // R1 strap mismatch and other preamble
        txn(8'hA2, 2, 8'h10);
        txn(8'h3B, -1, 8'h00);
        // R2 pin high protects upper half too
        set_pins(1, 3'b101, 0);
        txn(8'hAA, 3, 8'h80);
        // R10 reversible set with pin high: acked, no change
        set_pins(1, 3'b000, 1);
        txn(8'h62, 1, 8'h00);
        txn(8'h63, -1, 8'h00);
        // R7 set reversible
        set_pins(0, 3'b000, 1);
        txn(8'h62, 1, 8'h00);
        txn(8'h63, -1, 8'h00);
        txn(8'h62, 1, 8'h00);
        // R3 boundary 7Fh/80h
        set_pins(0, 3'b000, 0);
        txn(8'hA0, 2, 8'h7E);
        txn(8'hA0, 2, 8'h80);
        // R11 dummy write
        txn(8'hA0, 0, 8'h20);
        // R12 ack during busy
        txn(8'hA0, 1, 8'hC0);
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
        txn(8'hA0, 1, 8'h90);
        @(negedge clk) begin ctrl_valid = 1'b1; ctrl_byte = 8'hA0; end
        @(negedge clk) ctrl_valid = 1'b0;
        chk("R12 nack while busy", ack_ok, busy ? 0 : 1);
        wait_idle();
        // R12 explicit: start cycle, then control byte inside it
        begin
            byte_valid = 1'b0;
            @(negedge clk) bus_start = 1'b1;
            @(negedge clk) begin bus_start = 1'b0; ctrl_valid = 1'b1; ctrl_byte = 8'hA0; end
            @(negedge clk) begin ctrl_valid = 1'b0; byte_valid = 1'b1; byte_data = 8'hD0; end
            @(negedge clk) begin byte_valid = 1'b1; byte_data = 8'h11; end
            @(negedge clk) byte_valid = 1'b0;
            @(negedge clk) bus_stop = 1'b1;
            @(negedge clk) begin bus_stop = 1'b0; bus_start = 1'b1; end
            @(negedge clk) begin bus_start = 1'b0; ctrl_valid = 1'b1; ctrl_byte = 8'hA0; end
            @(negedge clk) ctrl_valid = 1'b0;
            chk("R12 control byte in write cycle nacked", ack_ok, 0);
            @(negedge clk) bus_stop = 1'b1;
            @(negedge clk) bus_stop = 1'b0;
            wait_idle();
            @(negedge clk);
        end
        // R8 clear reversible
        set_pins(0, 3'b010, 1);
        txn(8'h66, 1, 8'h00);
        set_pins(0, 3'b000, 1);
        txn(8'h63, -1, 8'h00);

        // constrained random, no permanent set command
        for (int n = 0; n < 300; n++) begin
            int cls;
            logic [2:0] s;
            logic [7:0] cb;
            int nb;
            cls = $urandom % 7;
            s = 3'($urandom);
            set_pins(($urandom % 4) == 0, s, 0);
            nb = int'($urandom % 21) - 1;
            case (cls)
                0: begin
                    cb = {4'hA, s, 1'b0};
                    if ($urandom % 8 == 0) cb[3:1] = ~s;
                end
                1: cb = {4'hA, s, 1'b1};
                2: begin set_pins(wp_pin, {2'b00, s[0]}, 1); cb = {7'b0110_001, 1'($urandom)}; nb = 1; end
                3: begin set_pins(wp_pin, {2'b01, s[0]}, 1); cb = {7'b0110_011, 1'($urandom)}; nb = 1; end
                4: cb = {4'h6, s, 1'b1};
                5: cb = {4'h3, 4'($urandom)};
                default: begin set_pins(wp_pin, s, 1); cb = 8'h6A; end
            endcase
            txn(cb, nb, 8'($urandom));
        end

        // R5 permanent set, then R6
        set_pins(0, 3'b011, 0);
        txn(8'h66, 1, 8'h00);
        txn(8'h67, -1, 8'h00);
        txn(8'h66, 1, 8'h00);
        txn(8'h66, 1, 8'h00);
        set_pins(0, 3'b000, 1);
        txn(8'h62, 1, 8'h00);
        txn(8'h63, -1, 8'h00);
        set_pins(0, 3'b010, 1);
        txn(8'h66, 1, 8'h00);
        set_pins(0, 3'b011, 0);
        txn(8'hA6, 2, 8'h7F);
        chk("R6 permanent flag model", m_perm, 1);

        // R13 presets
        do_reset(0, 1);
        set_pins(0, 3'b000, 1);
        txn(8'h63, -1, 8'h00);
        set_pins(0, 3'b000, 0);
        txn(8'h61, -1, 8'h00);
        txn(8'hA0, 1, 8'h05);
        do_reset(1, 0);
        txn(8'h61, -1, 8'h00);
        txn(8'hA0, 1, 8'hF5);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule